// File: doc/BRIEF.md
# Downward-Growing LIFO Stack with Full and Empty Flags

This block is a last-in-first-out store of `DEPTH` words (eleven by default), held in a small register file with slot addresses 0 to `DEPTH-1`. A stack pointer leaves reset at `DEPTH`, one above the highest slot, and moves toward zero as words are pushed. The word at the pointer is always the top of the stack. A push first moves the pointer down by one and then writes the input word into the slot it now names. A pop first reads the slot under the pointer into a registered output and then moves the pointer up by one.

Two status flags follow the pointer. FULL means the pointer has reached slot 0. EMPTY means the pointer is back at `DEPTH`. A command that cannot be served is rejected and leaves the pointer, the storage and the flags as they were. Such a command is a push while full, a pop while empty, or a push and a pop in the same cycle. The block raises a one-cycle error pulse for each rejected command. The popped word appears on the output one cycle after the pop command and stays there until the next accepted pop.

Top module: `lifo_stack_dn`

## Requirements
- R1: After reset, empty_o is 1, full_o is 0, err_o is 0 and dout_o is all zeros.
- R2: A push accepted while not full stores din_i as the new top word, and empty_o is 0 in the following cycle.
- R3: full_o rises in the cycle after the DEPTH-th accepted push from empty, and not before.
- R4: A pop accepted while not empty presents the most recently pushed word still held on dout_o in the following cycle, so words leave in the reverse of their arrival order.
- R5: A pop accepted while full clears full_o in the next cycle. empty_o is set in the cycle after the pop that removes the last word.
- R6: A push while full_o is 1 gives err_o = 1 for exactly the next cycle and changes neither the flags nor the stored words.
- R7: A pop while empty_o is 1 gives err_o = 1 for exactly the next cycle and leaves dout_o and the flags unchanged.
- R8: A push and a pop asserted in the same cycle are both ignored, and err_o is 1 in the next cycle.
- R9: dout_o changes only after an accepted pop. Pushes and idle cycles leave it holding its value.
- R10: err_o is 0 in the cycle after any accepted push, accepted pop or idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_i | input | 1 | Push command, sampled at the clock edge |
| pop_i | input | 1 | Pop command, sampled at the clock edge |
| din_i | input | WIDTH | Word written on an accepted push |
| dout_o | output | WIDTH | Registered word read by the last accepted pop |
| full_o | output | 1 | All DEPTH slots hold data |
| empty_o | output | 1 | No slot holds data |
| err_o | output | 1 | One-cycle pulse after a rejected command |

## Verification
The bench fills the stack to the last slot and then pushes once more. A pointer that wrapped past zero would corrupt the bottom word, and the full drain that follows would expose the change. Draining down to the bottom slot and popping one extra time shows whether an underflow moves the pointer or reloads the output; a faulty design would shift every later word or change dout_o. Simultaneous push and pop are driven on an empty stack, where a design that served either command would clear the empty flag or change the output. The bench also checks that the full flag is still low after one push fewer than the depth, which catches a bound that is off by one.

// File: rtl/lifo_stack_pkg.sv
package lifo_stack_pkg;

    // decoded command for one cycle
    typedef enum logic [1:0] {
        CMD_IDLE = 2'd0,
        CMD_PUSH = 2'd1,
        CMD_POP  = 2'd2,
        CMD_BAD  = 2'd3
    } stk_cmd_e;

endpackage

// File: rtl/lifo_stack_ctrl.sv
module lifo_stack_ctrl
    import lifo_stack_pkg::*;
#(
    parameter int DEPTH = 11,
    localparam int PW = $clog2(DEPTH + 1),
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic          pop_i,
    output logic          wr_en_o,
    output logic          rd_en_o,
    output logic [AW-1:0] addr_o,
    output logic [PW-1:0] sp_o,
    output logic          full_o,
    output logic          empty_o,
    output logic          err_o
);

    localparam logic [PW-1:0] SP_TOP = PW'(DEPTH);

    typedef struct packed {
        logic [PW-1:0] sp;
        logic          full;
        logic          empty;
        logic          err;
    } ctrl_t;

    ctrl_t    st_d, st_q;
    stk_cmd_e cmd;

    always_comb begin
        if (push_i && pop_i) begin
            cmd = CMD_BAD;
        end else if (push_i) begin
            cmd = st_q.full ? CMD_BAD : CMD_PUSH;
        end else if (pop_i) begin
            cmd = st_q.empty ? CMD_BAD : CMD_POP;
        end else begin
            cmd = CMD_IDLE;
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        wr_en_o  = 1'b0;
        rd_en_o  = 1'b0;
        addr_o   = AW'(st_q.sp);
        unique case (cmd)
            CMD_PUSH: begin
                st_d.sp    = st_q.sp - 1'b1;
                st_d.full  = (st_q.sp == PW'(1));
                st_d.empty = 1'b0;
                wr_en_o    = 1'b1;
                addr_o     = AW'(st_q.sp - 1'b1);
            end
            CMD_POP: begin
                st_d.sp    = st_q.sp + 1'b1;
                st_d.empty = (st_q.sp == SP_TOP - 1'b1);
                st_d.full  = 1'b0;
                rd_en_o    = 1'b1;
            end
            CMD_BAD: begin
                st_d.err = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sp    <= SP_TOP;
            st_q.full  <= 1'b0;
            st_q.empty <= 1'b1;
            st_q.err   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sp_o    = st_q.sp;
    assign full_o  = st_q.full;
    assign empty_o = st_q.empty;
    assign err_o   = st_q.err;

endmodule

// File: rtl/lifo_stack_store.sv
module lifo_stack_store #(
    parameter int DEPTH = 11,
    parameter int WIDTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic             rd_en_i,
    input  logic [AW-1:0]    addr_i,
    input  logic [WIDTH-1:0] wdata_i,
    output logic [WIDTH-1:0] rdata_o
);

    logic [WIDTH-1:0] cells [DEPTH];
    logic [WIDTH-1:0] rdata_d, rdata_q;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [WIDTH-1:0] cell_d, cell_q;

        always_comb begin
            cell_d = cell_q;
            if (wr_en_i && (addr_i == AW'(g))) begin
                cell_d = wdata_i;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cell_q <= '0;
            end else begin
                cell_q <= cell_d;
            end
        end

        assign cells[g] = cell_q;
    end

    always_comb begin
        rdata_d = rdata_q;
        if (rd_en_i) begin
            rdata_d = (32'(addr_i) < DEPTH) ? cells[addr_i] : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign rdata_o = rdata_q;

endmodule

// File: rtl/lifo_stack_dn.sv
module lifo_stack_dn #(
    parameter int DEPTH = 11,
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic [WIDTH-1:0] din_i,
    output logic [WIDTH-1:0] dout_o,
    output logic             full_o,
    output logic             empty_o,
    output logic             err_o
);

    localparam int PW = $clog2(DEPTH + 1);
    localparam int AW = $clog2(DEPTH);

    logic          wr_en_w;
    logic          rd_en_w;
    logic [AW-1:0] addr_w;
    logic [PW-1:0] sp_w;

    lifo_stack_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push_i),
        .pop_i   (pop_i),
        .wr_en_o (wr_en_w),
        .rd_en_o (rd_en_w),
        .addr_o  (addr_w),
        .sp_o    (sp_w),
        .full_o  (full_o),
        .empty_o (empty_o),
        .err_o   (err_o)
    );

    lifo_stack_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (wr_en_w),
        .rd_en_i (rd_en_w),
        .addr_i  (addr_w),
        .wdata_i (din_i),
        .rdata_o (dout_o)
    );

endmodule

// File: rtl/lifo_stack_chk.sv
module lifo_stack_chk #(
    parameter int DEPTH = 11,
    parameter int WIDTH = 16,
    localparam int PW = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             push_i,
    input logic             pop_i,
    input logic [WIDTH-1:0] dout_o,
    input logic             full_o,
    input logic             empty_o,
    input logic             err_o,
    input logic [PW-1:0]    sp_w
);

    // R3: full flag tracks the pointer reaching slot 0
    a_r3_full_at_bottom: assert property (@(posedge clk) disable iff (!rst_n)
        full_o == (sp_w == '0));

    // R5: empty flag tracks the pointer sitting above the top slot
    a_r5_empty_at_top: assert property (@(posedge clk) disable iff (!rst_n)
        empty_o == (sp_w == PW'(DEPTH)));

    // R2: accepted push lowers the pointer by one and clears empty
    a_r2_push_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && !full_o) |=> (sp_w == $past(sp_w) - 1'b1) && !empty_o && !err_o);

    // R4: accepted pop raises the pointer by one and clears full
    a_r4_pop_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && !empty_o) |=> (sp_w == $past(sp_w) + 1'b1) && !full_o && !err_o);

    // R6: overflowing push is rejected
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && full_o) |=> err_o && $stable(sp_w) && full_o);

    // R7: underflowing pop is rejected and the output holds
    a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && empty_o) |=> err_o && $stable(sp_w) && $stable(dout_o) && empty_o);

    // R8: simultaneous commands are rejected
    a_r8_both_rejected: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i) |=> err_o && $stable(sp_w) && $stable(dout_o));

    // R9: output changes only after a pop
    a_r9_dout_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !pop_i |=> $stable(dout_o));

    // R10: idle cycle leaves no error
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!push_i && !pop_i) |=> !err_o);

endmodule

bind lifo_stack_dn lifo_stack_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (push_i),
    .pop_i   (pop_i),
    .dout_o  (dout_o),
    .full_o  (full_o),
    .empty_o (empty_o),
    .err_o   (err_o),
    .sp_w    (sp_w)
);

// File: tb/sim_lifo_stack_dn.sv
module sim_lifo_stack_dn;

    localparam int DEPTH = 11;
    localparam int WIDTH = 16;
    localparam int NVEC  = 12;

    // {push, pop, din[15:0], err, empty, full, chk_dout, dout[15:0]}
    localparam logic [37:0] VEC [NVEC] = '{
        {1'b1, 1'b0, 16'h00A1, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0000},
        {1'b1, 1'b0, 16'h00B2, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0000},
        {1'b0, 1'b1, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b1, 16'h00B2},
        {1'b1, 1'b0, 16'h00C3, 1'b0, 1'b0, 1'b0, 1'b1, 16'h00B2},
        {1'b0, 1'b1, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b1, 16'h00C3},
        {1'b0, 1'b1, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b1, 16'h00A1},
        {1'b0, 1'b1, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b1, 16'h00A1},
        {1'b1, 1'b1, 16'h00D4, 1'b1, 1'b1, 1'b0, 1'b1, 16'h00A1},
        {1'b0, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b1, 16'h00A1},
        {1'b1, 1'b0, 16'h00E5, 1'b0, 1'b0, 1'b0, 1'b1, 16'h00A1},
        {1'b0, 1'b1, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b1, 16'h00E5},
        {1'b0, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b1, 16'h00E5}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             push_i = 1'b0;
    logic             pop_i = 1'b0;
    logic [WIDTH-1:0] din_i = '0;
    logic [WIDTH-1:0] dout_o;
    logic             full_o;
    logic             empty_o;
    logic             err_o;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    lifo_stack_dn #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push_i),
        .pop_i   (pop_i),
        .din_i   (din_i),
        .dout_o  (dout_o),
        .full_o  (full_o),
        .empty_o (empty_o),
        .err_o   (err_o)
    );

    task automatic check(input string tag, input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive one command at a falling edge; returns at the next falling edge
    task automatic step(input logic p, input logic q, input logic [WIDTH-1:0] d);
        push_i = p;
        pop_i  = q;
        din_i  = d;
        @(negedge clk);
        push_i = 1'b0;
        pop_i  = 1'b0;
    endtask

    initial begin
        #400000;
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check("R1 empty", 16'(empty_o), 16'd1);
        check("R1 full", 16'(full_o), 16'd0);
        check("R1 err", 16'(err_o), 16'd0);
        check("R1 dout", dout_o, 16'h0000);

        // table walk: R2 R4 R7 R8 R9 R10
        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][37], VEC[i][36], VEC[i][35:20]);
            check($sformatf("R7/R8/R10 err vec %0d", i), 16'(err_o), 16'(VEC[i][19]));
            check($sformatf("R2/R5 empty vec %0d", i), 16'(empty_o), 16'(VEC[i][18]));
            check($sformatf("R3 full vec %0d", i), 16'(full_o), 16'(VEC[i][17]));
            if (VEC[i][16]) begin
                check($sformatf("R4/R9 dout vec %0d", i), dout_o, VEC[i][15:0]);
            end
        end

        // fill: R3 not full one short of depth, full at depth
        for (int k = 0; k < DEPTH; k++) begin
            step(1'b1, 1'b0, 16'h0100 + 16'(k));
            if (k == DEPTH - 2) check("R3 not full one short", 16'(full_o), 16'd0);
        end
        check("R3 full at depth", 16'(full_o), 16'd1);
        check("R9 dout held over pushes", dout_o, 16'h00E5);

        // R6: push while full
        step(1'b1, 1'b0, 16'hDEAD);
        check("R6 err on overflow", 16'(err_o), 16'd1);
        check("R6 still full", 16'(full_o), 16'd1);
        step(1'b0, 1'b0, '0);
        check("R6 err one cycle", 16'(err_o), 16'd0);

        // R8 while full
        step(1'b1, 1'b1, 16'hBEEF);
        check("R8 err when full", 16'(err_o), 16'd1);
        check("R8 full kept", 16'(full_o), 16'd1);

        // drain: R4 LIFO order, R5 full clears, empty at end
        for (int k = DEPTH - 1; k >= 0; k--) begin
            step(1'b0, 1'b1, '0);
            check($sformatf("R4 lifo word %0d", k), dout_o, 16'h0100 + 16'(k));
            if (k == DEPTH - 1) check("R5 full cleared by pop", 16'(full_o), 16'd0);
            if (k == 1) check("R5 not empty before last", 16'(empty_o), 16'd0);
        end
        check("R5 empty after last pop", 16'(empty_o), 16'd1);
        check("R10 err quiet after pop", 16'(err_o), 16'd0);

        // R7: underflow keeps dout
        step(1'b0, 1'b1, '0);
        check("R7 err on underflow", 16'(err_o), 16'd1);
        check("R7 dout kept", dout_o, 16'h0100);
        check("R7 empty kept", 16'(empty_o), 16'd1);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule